// File: doc/BRIEF.md
# Interrupt-Capable Parallel I/O Port

This block is a parameterised parallel I/O port (eight pins by default) with per-pin interrupt detection. Each pin is either driven from an output value register or sampled as an input, as its direction bit selects. Input values pass through a two-stage synchroniser before software reads them and before any interrupt detection sees them.

Every pin has its own trigger settings. One bit chooses level or edge sensing and a second bit chooses the active sense: high or rising, or low or falling. An enable mask decides which pins may report. Edge events are held in a latch until software clears them by writing ones to an acknowledge address. Level conditions are not stored. They follow the synchronised pin for as long as the pin is enabled. The masked pending bits appear in a status register, on one interrupt output per pin, and ORed together on a single port interrupt.

A simple single-cycle register bus reaches the port. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: Pin i is an output when bit i of the direction register (address 1) is 1, and an input when that bit is 0. `pin_oe` equals the direction register and `pin_out` equals the output value register (address 0, write).
- R2: A read of address 0 returns the output value register for output pins and the synchronised pin level for input pins.
- R3: A change on `pin_in` reaches data reads after exactly two rising clock edges.
- R4: In level mode (trigger bit at address 2 = 0), an enabled pin is pending while its synchronised level equals its sense bit (address 3: 1 = high, 0 = low). The condition is never latched, and writes to the acknowledge address have no effect on it.
- R5: In edge mode (trigger bit = 1), an enabled pin latches a pending event on a rising edge (sense 1) or a falling edge (sense 0) of its synchronised input. The event stays pending after the pin returns to its idle level, and the opposite edge creates no event.
- R6: Writing a value to address 6 clears the latched edge event of every pin whose bit is 1 in that value. All other pins keep their latches. Address 6 reads as zero.
- R7: If a new selected edge arrives in the same cycle as an acknowledge of that pin, the latch stays set.
- R8: The enable register (address 4) masks the status. A pin that is disabled latches no edge, and clearing its enable bit discards any event it had pending.
- R9: Changing the trigger or sense bits of a pin, whether the pin is disabled or not, does not by itself create an edge event.
- R10: The status register (address 5) and `irq_pin` hold the masked pending bits. `irq_port` is the OR of those bits.
- R11: After reset, all configuration registers are zero, all pins are inputs, and no interrupt is pending.
- R12: Writes to address 5 (status) and address 6 change no configuration register. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from bus_addr |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output value for driven pins |
| pin_oe | output | WIDTH | Output enable per pin (1 = drive) |
| irq_pin | output | WIDTH | One interrupt line per pin |
| irq_port | output | 1 | Combined port interrupt |

## Verification
A wrong edge latch shows at the ports in one of two ways. Either a status bit stays set after an acknowledge, or a status bit appears where only an opposite-sense edge, a disabled pin or a type change occurred. This is visible on `irq_pin` three clock edges after the pin moves. A broken synchroniser shows as data reads that change one edge too early or too late. The acknowledge collision is driven on the exact cycle that the edge is detected, so that a design giving priority to the acknowledge loses the event at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_TRIG = 3'd2,
        REG_SENS = 3'd3,
        REG_EN   = 3'd4,
        REG_STAT = 3'd5,
        REG_ACK  = 3'd6,
        REG_NONE = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_async;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.stable;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] trig_edge,
    input  logic [WIDTH-1:0] sense_hi,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] pending
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] latch;
    } det_t;

    det_t det_d, det_q;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] level_hit;

    always_comb begin
        // The edge test uses only the pin history, never the sense history,
        // so a sense change cannot fake an edge.
        edge_hit  = (sense_hi & pin_sync & ~det_q.prev)
                  | (~sense_hi & ~pin_sync & det_q.prev);
        level_hit = ~(pin_sync ^ sense_hi);

        det_d       = det_q;
        det_d.prev  = pin_sync;
        det_d.latch = enable & trig_edge & ((det_q.latch & ~ack) | edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign pending = enable & ((trig_edge & det_q.latch) | (~trig_edge & level_hit));

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R5
        edge_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable[i] && trig_edge[i] && edge_hit[i]) |=> det_q.latch[i]);
        // R8
        latch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(det_q.latch[i]) |-> $past(enable[i] && trig_edge[i]));
        // R6
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !edge_hit[i]) |=> !det_q.latch[i]);
        // R7
        ack_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && edge_hit[i] && enable[i] && trig_edge[i]) |=> det_q.latch[i]);
        // R4
        level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_edge[i] |=> !det_q.latch[i]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_sync,
    input  logic [WIDTH-1:0]  pending,
    output logic [WIDTH-1:0]  out_val,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  trig_edge,
    output logic [WIDTH-1:0]  sense_hi,
    output logic [WIDTH-1:0]  enable,
    output logic [WIDTH-1:0]  ack
);
    typedef struct packed {
        logic [WIDTH-1:0] out_val;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] trig;
        logic [WIDTH-1:0] sense;
        logic [WIDTH-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(bus_addr);

    always_comb begin
        cfg_d = cfg_q;
        ack   = '0;
        if (bus_wr) begin
            unique case (sel)
                REG_DATA: cfg_d.out_val = bus_wdata;
                REG_DIR:  cfg_d.dir     = bus_wdata;
                REG_TRIG: cfg_d.trig    = bus_wdata;
                REG_SENS: cfg_d.sense   = bus_wdata;
                REG_EN:   cfg_d.en      = bus_wdata;
                REG_ACK:  ack           = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_DATA: bus_rdata = (cfg_q.dir & cfg_q.out_val) | (~cfg_q.dir & pin_sync);
            REG_DIR:  bus_rdata = cfg_q.dir;
            REG_TRIG: bus_rdata = cfg_q.trig;
            REG_SENS: bus_rdata = cfg_q.sense;
            REG_EN:   bus_rdata = cfg_q.en;
            REG_STAT: bus_rdata = pending;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign out_val   = cfg_q.out_val;
    assign dir       = cfg_q.dir;
    assign trig_edge = cfg_q.trig;
    assign sense_hi  = cfg_q.sense;
    assign enable    = cfg_q.en;

    // R12
    ro_addr_no_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == REG_STAT || sel == REG_ACK || sel == REG_NONE)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  irq_pin,
    output logic              irq_port
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] trig_edge, sense_hi, enable, ack, pending;

    gpio_irq_sync #(.WIDTH(WIDTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
    );

    gpio_irq_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_sync(pin_sync), .pending(pending),
        .out_val(pin_out), .dir(pin_oe),
        .trig_edge(trig_edge), .sense_hi(sense_hi), .enable(enable), .ack(ack)
    );

    gpio_irq_detect #(.WIDTH(WIDTH)) det_i (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
        .trig_edge(trig_edge), .sense_hi(sense_hi), .enable(enable), .ack(ack),
        .pending(pending)
    );

    assign irq_pin  = pending;
    assign irq_port = |pending;

    // R10
    port_irq_from_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_port == (irq_pin != '0));
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
    localparam int W = 8;
    // entry: kind[16:15] addr[14:12] data[11:4] req[3:0]
    // kind 0 = write, 1 = set pins and settle, 2 = read compare, 3 = irq compare
    localparam int NV = 58;
    localparam logic [16:0] TBL [NV] = '{
        {2'd0,3'd1,8'h0F,4'd1},  {2'd0,3'd0,8'hA5,4'd1},  {2'd1,3'd0,8'h30,4'd2},
        {2'd2,3'd0,8'h35,4'd2},  {2'd2,3'd1,8'h0F,4'd1},  {2'd1,3'd0,8'h00,4'd5},   // R1 R2
        {2'd0,3'd2,8'h10,4'd5},  {2'd0,3'd3,8'h10,4'd5},  {2'd0,3'd4,8'h10,4'd8},
        {2'd2,3'd5,8'h00,4'd8},  {2'd1,3'd0,8'h10,4'd5},  {2'd2,3'd5,8'h10,4'd5},   // R8 R5
        {2'd3,3'd0,8'h10,4'd10}, {2'd1,3'd0,8'h00,4'd5},  {2'd2,3'd5,8'h10,4'd5},   // R10
        {2'd0,3'd6,8'h10,4'd6},  {2'd2,3'd5,8'h00,4'd6},  {2'd3,3'd0,8'h00,4'd10},  // R6
        {2'd0,3'd3,8'h50,4'd4},  {2'd0,3'd4,8'h50,4'd4},  {2'd2,3'd5,8'h00,4'd4},   // R4
        {2'd1,3'd0,8'h40,4'd4},  {2'd2,3'd5,8'h40,4'd4},  {2'd0,3'd6,8'h40,4'd4},
        {2'd2,3'd5,8'h40,4'd4},  {2'd1,3'd0,8'h00,4'd4},  {2'd2,3'd5,8'h00,4'd4},
        {2'd0,3'd4,8'hD0,4'd4},  {2'd3,3'd0,8'h80,4'd4},  {2'd1,3'd0,8'h80,4'd4},
        {2'd3,3'd0,8'h00,4'd4},  {2'd0,3'd2,8'h30,4'd5},  {2'd0,3'd4,8'h30,4'd5},
        {2'd1,3'd0,8'hA0,4'd5},  {2'd2,3'd5,8'h00,4'd5},  {2'd1,3'd0,8'h80,4'd5},
        {2'd2,3'd5,8'h20,4'd5},  {2'd1,3'd0,8'h90,4'd5},  {2'd2,3'd5,8'h30,4'd5},
        {2'd0,3'd6,8'h10,4'd6},  {2'd2,3'd5,8'h20,4'd6},  {2'd3,3'd0,8'h20,4'd10},
        {2'd0,3'd4,8'h00,4'd8},  {2'd2,3'd5,8'h00,4'd8},  {2'd0,3'd4,8'h30,4'd8},
        {2'd2,3'd5,8'h00,4'd8},  {2'd1,3'd0,8'h80,4'd8},  {2'd0,3'd4,8'h00,4'd8},
        {2'd1,3'd0,8'h90,4'd8},  {2'd0,3'd4,8'h30,4'd8},  {2'd2,3'd5,8'h00,4'd8},
        {2'd0,3'd5,8'hFF,4'd12}, {2'd2,3'd5,8'h00,4'd12}, {2'd2,3'd6,8'h00,4'd12},  // R12
        {2'd2,3'd7,8'h00,4'd12}, {2'd2,3'd2,8'h30,4'd12}, {2'd2,3'd3,8'h50,4'd12},
        {2'd2,3'd4,8'h30,4'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe, irq_pin;
    logic irq_port;
    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_port(irq_port)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [W-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        check(req, irq_pin, exp);
        check(req, {{(W-1){1'b0}}, irq_port}, {{(W-1){1'b0}}, |exp});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", pin_oe, '0);
        check("R11", pin_out, '0);
        check("R11", irq_pin, '0);
        rst_n = 1'b1;
        rd_chk("R11", 3'd1, '0);
        rd_chk("R11", 3'd4, '0);

        for (int k = 0; k < NV; k++) begin
            logic [1:0] kind;
            logic [2:0] a;
            logic [W-1:0] d;
            string rq;
            kind = TBL[k][16:15];
            a    = TBL[k][14:12];
            d    = TBL[k][11:4];
            rq   = $sformatf("R%0d (vector %0d)", TBL[k][3:0], k);
            case (kind)
                2'd0: wr(a, d);
                2'd1: set_pins(d);
                2'd2: rd_chk(rq, a, d);
                default: irq_chk(rq, d);
            endcase
        end

        // R1 pin drive follows registers
        @(negedge clk);
        check("R1", pin_oe, 8'h0F);
        check("R1", pin_out, 8'hA5);

        // R3 two-edge synchroniser latency (pins now 0x90)
        @(negedge clk);
        pin_in = 8'h00;
        bus_addr = 3'd0;
        @(negedge clk);
        #1 check("R3", bus_rdata, 8'h95);
        @(negedge clk);
        #1 check("R3", bus_rdata, 8'h05);

        // R7 acknowledge colliding with a new edge
        repeat (3) @(negedge clk);
        wr(3'd6, 8'hFF);
        rd_chk("R6", 3'd5, 8'h00);
        set_pins(8'h10);
        rd_chk("R7", 3'd5, 8'h10);
        set_pins(8'h00);
        @(negedge clk);
        pin_in = 8'h10;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd6; bus_wdata = 8'h10; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R7", 3'd5, 8'h10);
        wr(3'd6, 8'h10);
        rd_chk("R6", 3'd5, 8'h00);

        // R9 type changes create no event (pin 4 held high)
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h40);
        wr(3'd2, 8'h20);
        wr(3'd2, 8'h30);
        wr(3'd4, 8'h30);
        repeat (3) @(negedge clk);
        rd_chk("R9", 3'd5, 8'h00);
        wr(3'd3, 8'h50);
        repeat (3) @(negedge clk);
        rd_chk("R9", 3'd5, 8'h00);
        irq_chk("R9", 8'h00);

        finish_run();
    end
endmodule